// File: doc/BRIEF.md
# Dual-Register Phase Accumulator Synthesizer Core

This block is the numeric heart of a direct digital synthesizer. An accumulator of `ACC_W` bits (32 by default) grows by a frequency tuning word on every sample clock. The output frequency is the tuning word times the sample clock frequency divided by 2^ACC_W. The top `PHASE_W` bits of the accumulator (12 by default) are added to a phase offset. The sum, modulo 2^PHASE_W, is handed to a downstream sine lookup table. One offset LSB is therefore 2π/2^PHASE_W radians. The lookup table and the DAC sit outside this block.

The block stores two tuning words and four phase offsets. A 1-bit frequency select and a 2-bit phase select choose the active pair. Each select comes either from a select register written over the control port or straight from external select pins. A source flag in the same register picks between the two. Three mode bits govern operation:
- sleep: freezes the accumulator and silences the output.
- zero: holds the accumulator at zero.
- wipe: clears every tuning and offset register.

All three mode bits come up set after reset, so the core stays silent until software releases it. Tuning words above half the sample clock frequency alias. Software must not program them.

Top module: `dds_phase_core`

## Requirements
- R1: After `rst_n` has been low at a clock edge, `acc_out` is 0, `phase_out` is 0, the sleep, zero and wipe mode bits are all set, the select register holds frequency 0 and offset 0, and the register source (`sel_use_pins` = 0) is in use.
- R2: When neither zero nor sleep is set, `acc_out` increases at each clock edge by the active tuning word, modulo 2^ACC_W.
- R3: When sleep is clear, `phase_out` equals `acc_out[ACC_W-1 -: PHASE_W]` plus the active phase offset, modulo 2^PHASE_W.
- R4: While zero is set, `acc_out` is held at 0. Consider a mode write that clears zero at edge k. `acc_out` first increases at edge k+1.
- R5: While sleep is set and zero is clear, `acc_out` keeps its value and `phase_out` reads 0.
- R6: While wipe is set, every tuning word and phase offset is forced to 0, and writes through `freq_we`/`phase_we` have no effect.
- R7: With the source flag at 1, the active selects follow `pin_freq`/`pin_phase`. With it at 0, they follow the select register loaded by `sel_we`.
- R8: In pin mode, a change on the pins becomes the active select at the next clock edge. The accumulator keeps its contents across the change and adds the newly selected word from the following edge on. In register mode, the change takes effect one edge after the `sel_we` write.
- R9: `freq_we` loads only the tuning word addressed by `freq_idx`, and `phase_we` loads only the offset addressed by `phase_idx` (index 0 to NUM-1). All other registers keep their values.
- R10: Zero takes priority over sleep. With both set, `acc_out` is 0 and `phase_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_we | input | 1 | Load a tuning word |
| freq_idx | input | $clog2(NUM_FREQ) | Tuning word index |
| freq_word | input | ACC_W | Tuning word value |
| phase_we | input | 1 | Load a phase offset |
| phase_idx | input | $clog2(NUM_PHASE) | Phase offset index |
| phase_word | input | PHASE_W | Phase offset value |
| mode_we | input | 1 | Load all three mode bits |
| mode_sleep | input | 1 | Sleep bit value |
| mode_zero | input | 1 | Accumulator-zero bit value |
| mode_wipe | input | 1 | Register-wipe bit value |
| sel_we | input | 1 | Load the select register |
| sel_use_pins | input | 1 | Source flag: 1 = pins, 0 = register |
| sel_freq | input | $clog2(NUM_FREQ) | Register frequency select |
| sel_phase | input | $clog2(NUM_PHASE) | Register phase select |
| pin_freq | input | $clog2(NUM_FREQ) | External frequency select pin |
| pin_phase | input | $clog2(NUM_PHASE) | External phase select pins |
| acc_out | output | ACC_W | Accumulator contents |
| phase_out | output | PHASE_W | Phase word for the lookup table |

## Verification
The bench builds the core with a 16-bit accumulator and a 6-bit phase word, keeping two tuning words and four offsets. This makes the accumulator wrap every dozen or so cycles and the output sum overflow often. Within a short run it sweeps every combination of select source, frequency select and phase select. An arithmetic model predicts the accumulator and output each cycle. Mode changes, wipe-time writes and pin toggling are all checked against that model.

// File: rtl/dds_core_pkg.sv
// Shared types for the phase accumulator synthesizer core.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package dds_core_pkg;

    // Operating mode bits held in the mode register.
    typedef struct packed {
        logic sleep;     // freeze accumulator, silence output
        logic zero_acc;  // hold accumulator at zero
        logic wipe;      // force tuning and offset registers to zero
    } dds_mode_t;

    localparam dds_mode_t MODE_POWERUP = '{sleep: 1'b1, zero_acc: 1'b1, wipe: 1'b1};

    // Where the active selects come from.
    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_PIN = 1'b1
    } dds_src_e;

endpackage

// File: rtl/dds_ctrl_regs.sv
// Mode register, select register and active-select pipeline.
// The active selects are registered each cycle from either the select
// register or the external pins, as chosen by the source flag.
// Assumes pins are already synchronous to clk.
module dds_ctrl_regs
    import dds_core_pkg::*;
#(
    parameter int NUM_FREQ  = 2,
    parameter int NUM_PHASE = 4,
    parameter int FSEL_W    = $clog2(NUM_FREQ),
    parameter int PSEL_W    = $clog2(NUM_PHASE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  dds_mode_t         mode_in,
    input  logic              sel_we,
    input  logic              sel_src_in,
    input  logic [FSEL_W-1:0] sel_freq_in,
    input  logic [PSEL_W-1:0] sel_phase_in,
    input  logic [FSEL_W-1:0] pin_freq,
    input  logic [PSEL_W-1:0] pin_phase,
    output dds_mode_t         mode_q,
    output logic [FSEL_W-1:0] fsel_act,
    output logic [PSEL_W-1:0] psel_act
);

    dds_src_e          src_q;
    logic [FSEL_W-1:0] fsel_reg;
    logic [PSEL_W-1:0] psel_reg;

    // Mode register: powers up with every mode bit set.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_POWERUP;
        else if (mode_we) mode_q <= mode_in;
    end

    // Select register: source flag plus register-driven selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= SRC_REG;
            fsel_reg <= '0;
            psel_reg <= '0;
        end else if (sel_we) begin
            src_q    <= dds_src_e'(sel_src_in);
            fsel_reg <= sel_freq_in;
            psel_reg <= sel_phase_in;
        end
    end

    // Active selects: registered from the chosen source every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel_act <= '0;
            psel_act <= '0;
        end else if (src_q == SRC_PIN) begin
            fsel_act <= pin_freq;
            psel_act <= pin_phase;
        end else begin
            fsel_act <= fsel_reg;
            psel_act <= psel_reg;
        end
    end

    // R7: in pin mode the active selects track the pins one edge later.
    p_pin_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_PIN) |=> (fsel_act == $past(pin_freq) && psel_act == $past(pin_phase)));

    // R7: in register mode the active selects track the select register.
    p_reg_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_REG) |=> (fsel_act == $past(fsel_reg) && psel_act == $past(psel_reg)));

endmodule

// File: rtl/dds_tuning_bank.sv
// Storage for NUM_FREQ tuning words and NUM_PHASE phase offsets, with
// the active word and offset muxed out by the given selects.
// Wipe forces all entries to zero and overrides writes.
// Assumes select values stay below their register counts.
module dds_tuning_bank #(
    parameter int ACC_W     = 32,
    parameter int PHASE_W   = 12,
    parameter int NUM_FREQ  = 2,
    parameter int NUM_PHASE = 4,
    parameter int FSEL_W    = $clog2(NUM_FREQ),
    parameter int PSEL_W    = $clog2(NUM_PHASE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe,
    input  logic               freq_we,
    input  logic [FSEL_W-1:0]  freq_idx,
    input  logic [ACC_W-1:0]   freq_word,
    input  logic               phase_we,
    input  logic [PSEL_W-1:0]  phase_idx,
    input  logic [PHASE_W-1:0] phase_word,
    input  logic [FSEL_W-1:0]  fsel,
    input  logic [PSEL_W-1:0]  psel,
    output logic [ACC_W-1:0]   ftw_sel,
    output logic [PHASE_W-1:0] off_sel
);

    logic [NUM_FREQ-1:0][ACC_W-1:0]    freq_q;
    logic [NUM_PHASE-1:0][PHASE_W-1:0] phase_q;

    for (genvar gi = 0; gi < NUM_FREQ; gi++) begin : g_freq
        // Tuning word entry: wipe wins, else indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                freq_q[gi] <= '0;
            else if (freq_we && freq_idx == FSEL_W'(gi))
                freq_q[gi] <= freq_word;
        end
    end

    for (genvar gj = 0; gj < NUM_PHASE; gj++) begin : g_phase
        // Phase offset entry: wipe wins, else indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                phase_q[gj] <= '0;
            else if (phase_we && phase_idx == PSEL_W'(gj))
                phase_q[gj] <= phase_word;
        end
    end

    // Active word and offset read-out.
    always_comb begin
        ftw_sel = freq_q[fsel];
        off_sel = phase_q[psel];
    end

    // R6: one edge after wipe is seen, every entry is zero.
    p_wipe_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (freq_q == '0 && phase_q == '0));

    // R9: without a write, a tuning entry keeps its value.
    p_freq_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && !freq_we) |=> $stable(freq_q));

endmodule

// File: rtl/dds_phase_accum.sv
// The phase accumulator and the output phase adder.
// Zero takes priority over sleep. Sleep freezes the accumulator and
// forces the output word to zero.
// Assumes ACC_W >= PHASE_W.
module dds_phase_accum #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zero_acc,
    input  logic               sleep,
    input  logic [ACC_W-1:0]   ftw,
    input  logic [PHASE_W-1:0] offset,
    output logic [ACC_W-1:0]   acc_q,
    output logic [PHASE_W-1:0] phase_word
);

    logic [PHASE_W-1:0] phase_sum;

    // Accumulator update with zero/sleep priority.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_acc) acc_q <= '0;
        else if (!sleep)        acc_q <= acc_q + ftw;
    end

    // Output word: top accumulator bits plus offset, silenced in sleep.
    always_comb begin
        phase_sum  = acc_q[ACC_W-1 -: PHASE_W] + offset;
        phase_word = sleep ? '0 : phase_sum;
    end

    // R4 / R10: the zero bit holds the accumulator at zero.
    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_acc |=> (acc_q == '0));

    // R5: sleep without zero freezes the accumulator.
    p_sleep_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !zero_acc) |=> (acc_q == $past(acc_q)));

    // R2: in run mode the accumulator steps by the active word.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !zero_acc) |=> (acc_q == $past(acc_q) + $past(ftw)));

endmodule

// File: rtl/dds_phase_core.sv
// Top of the synthesizer core: mode/select control, tuning storage and
// the accumulator, wired together.
// Assumes NUM_FREQ >= 2, NUM_PHASE >= 2, ACC_W >= PHASE_W.
module dds_phase_core
    import dds_core_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int PHASE_W   = 12,
    parameter int NUM_FREQ  = 2,
    parameter int NUM_PHASE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         freq_we,
    input  logic [$clog2(NUM_FREQ)-1:0]  freq_idx,
    input  logic [ACC_W-1:0]             freq_word,
    input  logic                         phase_we,
    input  logic [$clog2(NUM_PHASE)-1:0] phase_idx,
    input  logic [PHASE_W-1:0]           phase_word,
    input  logic                         mode_we,
    input  logic                         mode_sleep,
    input  logic                         mode_zero,
    input  logic                         mode_wipe,
    input  logic                         sel_we,
    input  logic                         sel_use_pins,
    input  logic [$clog2(NUM_FREQ)-1:0]  sel_freq,
    input  logic [$clog2(NUM_PHASE)-1:0] sel_phase,
    input  logic [$clog2(NUM_FREQ)-1:0]  pin_freq,
    input  logic [$clog2(NUM_PHASE)-1:0] pin_phase,
    output logic [ACC_W-1:0]             acc_out,
    output logic [PHASE_W-1:0]           phase_out
);

    localparam int FSEL_W = $clog2(NUM_FREQ);
    localparam int PSEL_W = $clog2(NUM_PHASE);

    dds_mode_t          mode_in;
    dds_mode_t          mode_q;
    logic [FSEL_W-1:0]  fsel_act;
    logic [PSEL_W-1:0]  psel_act;
    logic [ACC_W-1:0]   ftw_sel;
    logic [PHASE_W-1:0] off_sel;

    // Pack the mode write bits.
    always_comb begin
        mode_in = '{sleep: mode_sleep, zero_acc: mode_zero, wipe: mode_wipe};
    end

    dds_ctrl_regs #(
        .NUM_FREQ  (NUM_FREQ),
        .NUM_PHASE (NUM_PHASE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_we      (mode_we),
        .mode_in      (mode_in),
        .sel_we       (sel_we),
        .sel_src_in   (sel_use_pins),
        .sel_freq_in  (sel_freq),
        .sel_phase_in (sel_phase),
        .pin_freq     (pin_freq),
        .pin_phase    (pin_phase),
        .mode_q       (mode_q),
        .fsel_act     (fsel_act),
        .psel_act     (psel_act)
    );

    dds_tuning_bank #(
        .ACC_W     (ACC_W),
        .PHASE_W   (PHASE_W),
        .NUM_FREQ  (NUM_FREQ),
        .NUM_PHASE (NUM_PHASE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (mode_q.wipe),
        .freq_we    (freq_we),
        .freq_idx   (freq_idx),
        .freq_word  (freq_word),
        .phase_we   (phase_we),
        .phase_idx  (phase_idx),
        .phase_word (phase_word),
        .fsel       (fsel_act),
        .psel       (psel_act),
        .ftw_sel    (ftw_sel),
        .off_sel    (off_sel)
    );

    dds_phase_accum #(
        .ACC_W   (ACC_W),
        .PHASE_W (PHASE_W)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_acc   (mode_q.zero_acc),
        .sleep      (mode_q.sleep),
        .ftw        (ftw_sel),
        .offset     (off_sel),
        .acc_q      (acc_out),
        .phase_word (phase_out)
    );

    // R5 / R10: output is silent whenever the registered sleep bit is set.
    p_sleep_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.sleep |-> (phase_out == '0));

endmodule

// File: tb/dds_phase_core_tb.sv
// Self-checking bench with a small configuration and an arithmetic model.
module dds_phase_core_tb;

    localparam int ACC_W   = 16;
    localparam int PHASE_W = 6;
    localparam int NF      = 2;
    localparam int NP      = 4;
    localparam int FW      = $clog2(NF);
    localparam int PW      = $clog2(NP);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               freq_we, phase_we, mode_we, sel_we;
    logic [FW-1:0]      freq_idx, sel_freq, pin_freq;
    logic [PW-1:0]      phase_idx, sel_phase, pin_phase;
    logic [ACC_W-1:0]   freq_word;
    logic [PHASE_W-1:0] phase_word;
    logic               mode_sleep, mode_zero, mode_wipe, sel_use_pins;
    logic [ACC_W-1:0]   acc_out;
    logic [PHASE_W-1:0] phase_out;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    dds_phase_core #(
        .ACC_W (ACC_W), .PHASE_W (PHASE_W), .NUM_FREQ (NF), .NUM_PHASE (NP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .freq_we (freq_we), .freq_idx (freq_idx), .freq_word (freq_word),
        .phase_we (phase_we), .phase_idx (phase_idx), .phase_word (phase_word),
        .mode_we (mode_we), .mode_sleep (mode_sleep), .mode_zero (mode_zero),
        .mode_wipe (mode_wipe), .sel_we (sel_we), .sel_use_pins (sel_use_pins),
        .sel_freq (sel_freq), .sel_phase (sel_phase),
        .pin_freq (pin_freq), .pin_phase (pin_phase),
        .acc_out (acc_out), .phase_out (phase_out)
    );

    // Arithmetic model of the requirements.
    logic [ACC_W-1:0]   m_f [NF];
    logic [PHASE_W-1:0] m_p [NP];
    logic               m_sleep, m_zero, m_wipe, m_src;
    logic [FW-1:0]      m_fs, m_fa;
    logic [PW-1:0]      m_ps, m_pa;
    logic [ACC_W-1:0]   m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) m_f[i] <= '0;
            for (int i = 0; i < NP; i++) m_p[i] <= '0;
            m_sleep <= 1'b1; m_zero <= 1'b1; m_wipe <= 1'b1;
            m_src <= 1'b0; m_fs <= '0; m_ps <= '0; m_fa <= '0; m_pa <= '0;
            m_acc <= '0;
        end else begin
            for (int i = 0; i < NF; i++)
                if (m_wipe) m_f[i] <= '0;
                else if (freq_we && int'(freq_idx) == i) m_f[i] <= freq_word;
            for (int i = 0; i < NP; i++)
                if (m_wipe) m_p[i] <= '0;
                else if (phase_we && int'(phase_idx) == i) m_p[i] <= phase_word;
            if (mode_we) begin
                m_sleep <= mode_sleep; m_zero <= mode_zero; m_wipe <= mode_wipe;
            end
            if (sel_we) begin
                m_src <= sel_use_pins; m_fs <= sel_freq; m_ps <= sel_phase;
            end
            m_fa <= m_src ? pin_freq  : m_fs;
            m_pa <= m_src ? pin_phase : m_ps;
            if (m_zero)        m_acc <= '0;
            else if (!m_sleep) m_acc <= m_acc + m_f[m_fa];
        end
    end

    task automatic compare();
        logic [PHASE_W-1:0] exp_ph;
        exp_ph = m_acc[ACC_W-1 -: PHASE_W] + m_p[m_pa];
        if (m_sleep) exp_ph = '0;
        checks++;
        if (acc_out !== m_acc) begin
            errors++;
            $display("FAIL %s acc_out actual %h expected %h", cur_tag, acc_out, m_acc);
        end
        checks++;
        if (phase_out !== exp_ph) begin
            errors++;
            $display("FAIL %s phase_out actual %h expected %h", cur_tag, phase_out, exp_ph);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_mode(logic s, logic z, logic w);
        mode_we = 1'b1; mode_sleep = s; mode_zero = z; mode_wipe = w;
        tick();
        mode_we = 1'b0;
    endtask

    task automatic load_freq(int idx, logic [ACC_W-1:0] v);
        freq_we = 1'b1; freq_idx = FW'(idx); freq_word = v;
        tick();
        freq_we = 1'b0;
    endtask

    task automatic load_phase(int idx, logic [PHASE_W-1:0] v);
        phase_we = 1'b1; phase_idx = PW'(idx); phase_word = v;
        tick();
        phase_we = 1'b0;
    endtask

    task automatic load_sel(logic pins, int fs, int ps);
        sel_we = 1'b1; sel_use_pins = pins; sel_freq = FW'(fs); sel_phase = PW'(ps);
        tick();
        sel_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        freq_we = 0; phase_we = 0; mode_we = 0; sel_we = 0;
        freq_idx = '0; sel_freq = '0; pin_freq = '0;
        phase_idx = '0; sel_phase = '0; pin_phase = '0;
        freq_word = '0; phase_word = '0;
        mode_sleep = 0; mode_zero = 0; mode_wipe = 0; sel_use_pins = 0;

        // R1: reset state.
        cur_tag = "R1";
        run(2);
        rst_n = 1'b1;
        run(3);

        // R6: writes during wipe are lost; released core then runs on zeros.
        cur_tag = "R6";
        load_freq(0, 16'h1234);
        load_phase(0, 6'd9);
        set_mode(1'b0, 1'b0, 1'b0);
        run(4);

        // R9: indexed loads reach only the addressed entry.
        cur_tag = "R9";
        load_freq(0, 16'h1234);
        load_freq(1, 16'h0F01);
        load_phase(0, 6'd0);
        load_phase(1, 6'd17);
        load_phase(2, 6'd42);
        load_phase(3, 6'd63);
        run(3);

        // R4: zero holds, counting resumes the edge after release.
        cur_tag = "R4";
        set_mode(1'b0, 1'b1, 1'b0);
        run(3);
        set_mode(1'b0, 1'b0, 1'b0);
        run(4);

        // R2, R3, R7: sweep of source, frequency and phase selects.
        for (int src = 0; src < 2; src++) begin
            for (int fs = 0; fs < NF; fs++) begin
                for (int ps = 0; ps < NP; ps++) begin
                    cur_tag = (src == 1) ? "R7" : ((ps == 0) ? "R2" : "R3");
                    if (src == 0) begin
                        load_sel(1'b0, fs, ps);
                    end else begin
                        pin_freq = FW'(fs); pin_phase = PW'(ps);
                        load_sel(1'b1, 0, 0);
                    end
                    run(8);
                end
            end
        end

        // R8: pin toggling each cycle leaves the accumulator undisturbed.
        cur_tag = "R8";
        for (int i = 0; i < 12; i++) begin
            pin_freq  = FW'(i % NF);
            pin_phase = PW'((i * 3) % NP);
            tick();
        end

        // R9: rewriting the idle tuning word leaves the active one in use.
        cur_tag = "R9";
        pin_freq = '0;
        tick();
        load_freq(1, 16'h7777);
        run(4);

        // R5: sleep freezes and silences, then release.
        cur_tag = "R5";
        set_mode(1'b1, 1'b0, 1'b0);
        run(5);
        set_mode(1'b0, 1'b0, 1'b0);
        run(3);

        // R10: zero outranks sleep.
        cur_tag = "R10";
        set_mode(1'b1, 1'b1, 1'b0);
        run(3);
        set_mode(1'b1, 1'b0, 1'b0);
        run(3);
        set_mode(1'b0, 1'b0, 1'b0);
        run(4);

        // R6: wipe at runtime clears the stored words and offsets.
        cur_tag = "R6";
        set_mode(1'b0, 1'b0, 1'b1);
        load_freq(0, 16'h0101);
        run(2);
        set_mode(1'b0, 1'b0, 1'b0);
        run(3);

        finish_run();
    end

endmodule